// File: doc/BRIEF.md
# NOR Flash Program and Erase Sequencer

This block drives the write side of a parallel NOR flash that runs its own internal program and erase algorithms. A client hands it a single command: a word program, an erase of any subset of eight equal sectors, or a full chip erase. The sequencer then produces the unlock and command bus writes on the flash pins, with strobe widths set by cycle-count parameters. After the last write it reads the flash repeatedly and watches data bit 7 until the operation has finished. When the operation completes, or when its time limit runs out, it returns a one-cycle result pulse.

The flash word address is split into a sector index (the top bits) and an offset within the sector. Each operation class has a maximum duration, given in microseconds. A clock-frequency parameter converts these limits into cycle counts.

The controller states are:
- `ST_IDLE`: waiting for a command.
- `ST_UNLK1` and `ST_UNLK2`: the first two unlock writes.
- `ST_SETUP`: writes the program or erase-setup code.
- `ST_PGM_WR`: writes the target address and data of a program.
- `ST_ERS_UNLK1` and `ST_ERS_UNLK2`: the second unlock pair of an erase.
- `ST_ERS_GO`: writes the chip-erase code, or one sector-erase write per selected sector.
- `ST_POLL`: repeated status reads.

The transitions are:
- `ST_IDLE` to `ST_UNLK1` on an accepted command.
- `ST_UNLK1` to `ST_UNLK2` to `ST_SETUP`, each step at the end of a bus write.
- `ST_SETUP` to `ST_PGM_WR` for a program, or to `ST_ERS_UNLK1` for an erase.
- `ST_PGM_WR` to `ST_POLL`.
- `ST_ERS_UNLK1` to `ST_ERS_UNLK2` to `ST_ERS_GO`.
- `ST_ERS_GO` stays in place while more sectors are pending, then goes to `ST_POLL`.
- `ST_POLL` to `ST_IDLE` on completion or on timeout.

Top module: `nor_prog_seq`

## Requirements
- R1: After reset `busy_o`, `done_o` and `err_o` are 0, and `fl_we_n`, `fl_oe_n` and `fl_ce_n` are 1. While idle, all three flash strobes stay high.
- R2: A program command (`cmd_op`=0) produces exactly four writes, as (address, data) pairs: (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0xA0), then (`cmd_addr`, `cmd_data`).
- R3: Each bus write holds `fl_we_n` low for WE_LOW_CYC cycles. Between writes the strobe is high for at least WE_HIGH_CYC cycles. Address and write data stay stable while the strobe is low. `fl_we_n` and `fl_oe_n` are never low together, and `fl_ce_n` is low whenever either of them is low.
- R4: A sector erase (`cmd_op`=1) writes (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0x80), (0x555, 0xAA) and (0x2AA, 0x55). It then writes 0x30 to the base address of each set bit of `cmd_sectors`, in ascending sector order. Polling then reads the base of the lowest selected sector. Sector n has base address n shifted left by ADDR_W-3 bits.
- R5: During polling, the operation counts as finished only when `fl_rdata` bit 7 equals the expected value. For a program this is bit 7 of `cmd_data`; for an erase it is 1. The program poll address is `cmd_addr`. On completion `done_o` pulses for one cycle, in the same cycle that `busy_o` falls.
- R6: A chip erase (`cmd_op`=2) produces the same five setup writes as a sector erase, then one write of (0x555, 0x10), then polling at address 0.
- R7: If polling has not finished after the limit for the operation, `err_o` pulses once and the block returns to idle. The limit in cycles is the operation's microsecond limit times CLK_MHZ. `done_o` and `err_o` are never high together.
- R8: A sector erase with an all-zero mask, or the reserved opcode 3, produces an `err_o` pulse on the cycle after the command and no bus write.
- R9: A command offered while `busy_o` is high is ignored. The running operation's write sequence and result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 reserved |
| cmd_addr | input | ADDR_W | Program target word address |
| cmd_data | input | DATA_W | Program data |
| cmd_sectors | input | SECT_N | Sector-erase selection mask, bit n for sector n |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle error pulse (timeout or rejected command) |
| fl_addr | output | ADDR_W | Flash address |
| fl_wdata | output | DATA_W | Flash write data |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_rdata | input | DATA_W | Flash read data |

## Verification
The program command is run twice, once with data bit 7 clear and once with it set. A short flash delay and a long one show that completion follows the true bit 7 and not its complement. A three-sector mask with gaps shows the ascending write order and the choice of poll address. A chip erase shows the single global erase write. A program and a sector erase that never complete show that each operation applies its own time limit. A zero mask, the reserved opcode and a command offered mid-operation show the reject and ignore paths, judged by the bus write log and the result pulses.

// File: rtl/nps_pkg.sv
package nps_pkg;
    typedef enum logic [1:0] {
        OP_PROG   = 2'd0,
        OP_SERASE = 2'd1,
        OP_CERASE = 2'd2,
        OP_RSVD   = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UNLK1,
        ST_UNLK2,
        ST_SETUP,
        ST_PGM_WR,
        ST_ERS_UNLK1,
        ST_ERS_UNLK2,
        ST_ERS_GO,
        ST_POLL
    } st_e;

    localparam logic [10:0] ADR_KEY_A  = 11'h555;
    localparam logic [10:0] ADR_KEY_B  = 11'h2AA;
    localparam logic [7:0]  CODE_KEY_A = 8'hAA;
    localparam logic [7:0]  CODE_KEY_B = 8'h55;
    localparam logic [7:0]  CODE_PROG  = 8'hA0;
    localparam logic [7:0]  CODE_ESET  = 8'h80;
    localparam logic [7:0]  CODE_SECT  = 8'h30;
    localparam logic [7:0]  CODE_CHIP  = 8'h10;
    localparam int          POLL_BIT   = 7;
endpackage

// File: rtl/nps_strobe.sv
module nps_strobe #(
    parameter int LOW_CYC  = 6,
    parameter int HIGH_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic strobe_n,
    output logic phase_end
);
    localparam int TOT = LOW_CYC + HIGH_CYC;
    localparam int CW  = $clog2(TOT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       cnt <= '0;
        else if (!req)                    cnt <= '0;
        else if (cnt == CW'(TOT - 1))     cnt <= '0;
        else                              cnt <= cnt + 1'b1;
    end

    assign strobe_n  = !(req && cnt < CW'(LOW_CYC));
    assign phase_end = req && (cnt == CW'(LOW_CYC - 1) || cnt == CW'(TOT - 1));
endmodule

// File: rtl/nps_pick.sv
module nps_pick #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] mask,
    output logic [W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/nps_timer.sv
module nps_timer #(
    parameter int CW = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (!run) cnt <= '0;
        else if (!expired) cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt >= limit - 1'b1);
endmodule

// File: rtl/nor_prog_seq.sv
module nor_prog_seq
    import nps_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int DATA_W      = 16,
    parameter int SECT_N      = 8,
    parameter int CLK_MHZ     = 125,
    parameter int PGM_MAX_US  = 300,
    parameter int SEC_MAX_US  = 15_000_000,
    parameter int CHIP_MAX_US = 64_000_000,
    parameter int WE_LOW_CYC  = 6,
    parameter int WE_HIGH_CYC = 6,
    parameter int OE_LOW_CYC  = 12,
    parameter int OE_HIGH_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [SECT_N-1:0] cmd_sectors,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_wdata,
    output logic              fl_we_n,
    output logic              fl_oe_n,
    output logic              fl_ce_n,
    input  logic [DATA_W-1:0] fl_rdata
);
    localparam int SECT_W = $clog2(SECT_N);
    localparam int SPAN_W = ADDR_W - SECT_W;
    localparam longint unsigned PGM_CYC  = longint'(PGM_MAX_US)  * longint'(CLK_MHZ);
    localparam longint unsigned SEC_CYC  = longint'(SEC_MAX_US)  * longint'(CLK_MHZ);
    localparam longint unsigned CHIP_CYC = longint'(CHIP_MAX_US) * longint'(CLK_MHZ);
    localparam longint unsigned MAX_CYC  =
        (PGM_CYC > SEC_CYC) ? ((PGM_CYC > CHIP_CYC) ? PGM_CYC : CHIP_CYC)
                            : ((SEC_CYC > CHIP_CYC) ? SEC_CYC : CHIP_CYC);
    localparam int CNT_W = $clog2(MAX_CYC + 1);

    st_e               state, nxt;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [SECT_N-1:0] pend_q, pend_rest;
    logic [SECT_W-1:0] first_q, cur_sec, cmd_first;
    logic              wr_req, rd_req, wr_end, rd_end, wr_fin, rd_sample;
    logic              tmo, want7, accept, done_d, err_d;
    logic [CNT_W-1:0]  limit;

    assign wr_req    = state inside {ST_UNLK1, ST_UNLK2, ST_SETUP, ST_PGM_WR,
                                     ST_ERS_UNLK1, ST_ERS_UNLK2, ST_ERS_GO};
    assign rd_req    = (state == ST_POLL);
    assign wr_fin    = wr_end && fl_we_n;
    assign rd_sample = rd_end && !fl_oe_n;
    assign pend_rest = pend_q & ~(SECT_N'(1) << cur_sec);
    assign want7     = (op_q == OP_PROG) ? data_q[POLL_BIT] : 1'b1;

    always_comb begin
        unique case (op_q)
            OP_PROG:   limit = CNT_W'(PGM_CYC);
            OP_SERASE: limit = CNT_W'(SEC_CYC);
            default:   limit = CNT_W'(CHIP_CYC);
        endcase
    end

    nps_strobe #(.LOW_CYC(WE_LOW_CYC), .HIGH_CYC(WE_HIGH_CYC)) u_wr (
        .clk(clk), .rst_n(rst_n), .req(wr_req), .strobe_n(fl_we_n), .phase_end(wr_end));
    nps_strobe #(.LOW_CYC(OE_LOW_CYC), .HIGH_CYC(OE_HIGH_CYC)) u_rd (
        .clk(clk), .rst_n(rst_n), .req(rd_req), .strobe_n(fl_oe_n), .phase_end(rd_end));
    nps_pick #(.N(SECT_N)) u_pick_cur (.mask(pend_q),      .idx(cur_sec));
    nps_pick #(.N(SECT_N)) u_pick_cmd (.mask(cmd_sectors), .idx(cmd_first));
    nps_timer #(.CW(CNT_W)) u_tmo (
        .clk(clk), .rst_n(rst_n), .run(rd_req), .limit(limit), .expired(tmo));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt    = state;
        accept = 1'b0;
        done_d = 1'b0;
        err_d  = 1'b0;
        unique case (state)
            ST_IDLE: if (cmd_valid) begin
                if (op_e'(cmd_op) == OP_RSVD ||
                    (op_e'(cmd_op) == OP_SERASE && cmd_sectors == '0)) err_d = 1'b1;
                else begin
                    accept = 1'b1;
                    nxt    = ST_UNLK1;
                end
            end
            ST_UNLK1:     if (wr_fin) nxt = ST_UNLK2;
            ST_UNLK2:     if (wr_fin) nxt = ST_SETUP;
            ST_SETUP:     if (wr_fin) nxt = (op_q == OP_PROG) ? ST_PGM_WR : ST_ERS_UNLK1;
            ST_PGM_WR:    if (wr_fin) nxt = ST_POLL;
            ST_ERS_UNLK1: if (wr_fin) nxt = ST_ERS_UNLK2;
            ST_ERS_UNLK2: if (wr_fin) nxt = ST_ERS_GO;
            ST_ERS_GO:    if (wr_fin && (op_q == OP_CERASE || pend_rest == '0)) nxt = ST_POLL;
            ST_POLL: begin
                if (rd_sample && fl_rdata[POLL_BIT] == want7) begin
                    nxt    = ST_IDLE;
                    done_d = 1'b1;
                end else if (tmo) begin
                    nxt   = ST_IDLE;
                    err_d = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Registered command context and result pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_PROG;
            addr_q  <= '0;
            data_q  <= '0;
            pend_q  <= '0;
            first_q <= '0;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            done_o <= done_d;
            err_o  <= err_d;
            if (accept) begin
                op_q    <= op_e'(cmd_op);
                addr_q  <= cmd_addr;
                data_q  <= cmd_data;
                pend_q  <= cmd_sectors;
                first_q <= cmd_first;
            end else if (state == ST_ERS_GO && wr_fin) begin
                pend_q <= pend_rest;
            end
        end
    end

    // Bus outputs
    always_comb begin
        fl_addr  = '0;
        fl_wdata = '0;
        unique case (state)
            ST_UNLK1, ST_ERS_UNLK1: begin
                fl_addr  = ADDR_W'(ADR_KEY_A);
                fl_wdata = DATA_W'(CODE_KEY_A);
            end
            ST_UNLK2, ST_ERS_UNLK2: begin
                fl_addr  = ADDR_W'(ADR_KEY_B);
                fl_wdata = DATA_W'(CODE_KEY_B);
            end
            ST_SETUP: begin
                fl_addr  = ADDR_W'(ADR_KEY_A);
                fl_wdata = DATA_W'((op_q == OP_PROG) ? CODE_PROG : CODE_ESET);
            end
            ST_PGM_WR: begin
                fl_addr  = addr_q;
                fl_wdata = data_q;
            end
            ST_ERS_GO: begin
                if (op_q == OP_CERASE) begin
                    fl_addr  = ADDR_W'(ADR_KEY_A);
                    fl_wdata = DATA_W'(CODE_CHIP);
                end else begin
                    fl_addr  = {cur_sec, {SPAN_W{1'b0}}};
                    fl_wdata = DATA_W'(CODE_SECT);
                end
            end
            ST_POLL: begin
                if (op_q == OP_PROG)        fl_addr = addr_q;
                else if (op_q == OP_SERASE) fl_addr = {first_q, {SPAN_W{1'b0}}};
            end
            default: ;
        endcase
    end

    assign fl_ce_n = !(wr_req || rd_req);
    assign busy_o  = (state != ST_IDLE);
endmodule

// File: rtl/nps_checks.sv
module nps_checks #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [DATA_W-1:0] fl_wdata,
    input logic              fl_we_n,
    input logic              fl_oe_n,
    input logic              fl_ce_n
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (fl_we_n && fl_oe_n && fl_ce_n)); // R1
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_oe_n)); // R3
    AST_CE_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n || !fl_oe_n) |-> !fl_ce_n); // R3
    AST_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && !$past(fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_wdata))); // R3
    AST_WE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |=> fl_we_n); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R5
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (done_o || err_o)); // R5
    AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o)); // R7
endmodule

bind nor_prog_seq nps_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checks (
    .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we_n(fl_we_n),
    .fl_oe_n(fl_oe_n), .fl_ce_n(fl_ce_n));

// File: tb/nor_prog_seq_test.sv
module nor_prog_seq_test;
    localparam int AW = 19, DW = 16, SN = 8;
    localparam int MHZ = 125, PGM_US = 20, SEC_US = 30, CHIP_US = 40;
    localparam int WLO = 6, WHI = 6;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic [SN-1:0] cmd_sectors = '0;
    logic          busy_o, done_o, err_o, fl_we_n, fl_oe_n, fl_ce_n;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_wdata, fl_rdata;

    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    nor_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .SECT_N(SN), .CLK_MHZ(MHZ),
        .PGM_MAX_US(PGM_US), .SEC_MAX_US(SEC_US), .CHIP_MAX_US(CHIP_US),
        .WE_LOW_CYC(WLO), .WE_HIGH_CYC(WHI), .OE_LOW_CYC(12), .OE_HIGH_CYC(2)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_sectors(cmd_sectors),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .fl_addr(fl_addr),
        .fl_wdata(fl_wdata), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
        .fl_ce_n(fl_ce_n), .fl_rdata(fl_rdata));

    // Flash stub: write log, strobe widths, data-bit-7 polling behaviour
    logic [AW-1:0] wa [0:15];
    logic [DW-1:0] wd [0:15];
    int            nw = 0, lowrun = 0, hrun = 100, bad_low = 0, bad_high = 0;
    logic [AW-1:0] cur_a, poll_a;
    logic [DW-1:0] cur_d, tgt = '0;
    logic          prev_we = 1'b1, after_a0 = 1'b0;
    int            stub_cnt = 0, stub_delay = 20;
    bit            stub_hang = 1'b0;

    assign fl_rdata = (stub_cnt > 0) ? (tgt ^ 16'h0080) : tgt;

    always @(negedge clk) begin
        if (stub_cnt > 0 && !stub_hang) stub_cnt <= stub_cnt - 1;
        if (!fl_oe_n) poll_a <= fl_addr;
        if (!fl_we_n) begin
            if (prev_we && hrun < WHI) bad_high++;
            lowrun++; cur_a = fl_addr; cur_d = fl_wdata; hrun = 0;
        end else begin
            hrun++;
            if (!prev_we) begin
                if (lowrun != WLO) bad_low++;
                lowrun = 0;
                if (nw < 16) begin wa[nw] = cur_a; wd[nw] = cur_d; end
                nw++;
                if (after_a0) begin
                    tgt = cur_d; stub_cnt <= stub_hang ? 1 : stub_delay;
                end else if (cur_d == 16'h30 || cur_d == 16'h10) begin
                    tgt = 16'hFFFF; stub_cnt <= stub_hang ? 1 : stub_delay;
                end
                after_a0 = (cur_d == 16'hA0);
            end
        end
        prev_we = fl_we_n;
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", rq, what, act, exp);
        end
    endtask

    task automatic clear_log();
        nw = 0; bad_low = 0; bad_high = 0; stub_hang = 1'b0; after_a0 = 1'b0;
    endtask

    task automatic issue(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic [SN-1:0] m);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_sectors = m;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_end(output bit got_done, output bit got_err, output int cyc);
        got_done = 0; got_err = 0; cyc = 1;
        while (!done_o && !err_o && cyc < 20000) begin
            @(negedge clk); cyc++;
        end
        got_done = done_o; got_err = err_o;
    endtask

    task automatic chk_write(input string rq, input int i,
                             input logic [AW-1:0] a, input logic [DW-1:0] d);
        chk(wa[i] == a, rq, $sformatf("write %0d addr", i), wa[i], a);
        chk(wd[i] == d, rq, $sformatf("write %0d data", i), wd[i], d);
    endtask

    task automatic t_reset();
        chk(!busy_o && !done_o && !err_o, "R1", "status after reset",
            {busy_o, done_o, err_o}, 0);
        chk(fl_we_n && fl_oe_n && fl_ce_n, "R1", "strobes after reset",
            {fl_we_n, fl_oe_n, fl_ce_n}, 3'b111);
    endtask

    task automatic t_program(input logic [AW-1:0] a, input logic [DW-1:0] d, input int dly);
        bit gd, ge; int cyc;
        clear_log(); stub_delay = dly;
        issue(2'd0, a, d, '0);
        wait_end(gd, ge, cyc);
        chk(nw == 4, "R2", "program write count", nw, 4);
        chk_write("R2", 0, 19'h555, 16'hAA);
        chk_write("R2", 1, 19'h2AA, 16'h55);
        chk_write("R2", 2, 19'h555, 16'hA0);
        chk_write("R2", 3, a, d);
        chk(bad_low == 0 && bad_high == 0, "R3", "strobe widths", bad_low + bad_high, 0);
        chk(gd && !ge, "R5", "program done", {gd, ge}, 2'b10);
        chk(!busy_o, "R5", "busy falls with done", busy_o, 0);
        chk(poll_a == a, "R5", "program poll address", poll_a, a);
        chk(cyc > dly, "R5", "not done while bit 7 complemented", cyc, dly);
        @(negedge clk);
        chk(!done_o, "R5", "done is one cycle", done_o, 0);
    endtask

    task automatic t_sector_erase();
        bit gd, ge; int cyc;
        clear_log(); stub_delay = 40;
        issue(2'd1, '0, '0, 8'b1010_0100);
        wait_end(gd, ge, cyc);
        chk(nw == 8, "R4", "sector erase write count", nw, 8);
        chk_write("R4", 2, 19'h555, 16'h80);
        chk_write("R4", 4, 19'h2AA, 16'h55);
        chk_write("R4", 5, 19'h20000, 16'h30);
        chk_write("R4", 6, 19'h50000, 16'h30);
        chk_write("R4", 7, 19'h70000, 16'h30);
        chk(poll_a == 19'h20000, "R4", "erase poll address", poll_a, 19'h20000);
        chk(gd && !ge, "R5", "sector erase done", {gd, ge}, 2'b10);
        chk(bad_low == 0 && bad_high == 0, "R3", "erase strobe widths", bad_low + bad_high, 0);
    endtask

    task automatic t_chip_erase();
        bit gd, ge; int cyc;
        clear_log(); stub_delay = 30;
        issue(2'd2, '0, '0, '0);
        wait_end(gd, ge, cyc);
        chk(nw == 6, "R6", "chip erase write count", nw, 6);
        chk_write("R6", 3, 19'h555, 16'hAA);
        chk_write("R6", 5, 19'h555, 16'h10);
        chk(poll_a == '0, "R6", "chip poll address", poll_a, 0);
        chk(gd && !ge, "R6", "chip erase done", {gd, ge}, 2'b10);
    endtask

    task automatic t_timeout(input logic [1:0] op, input logic [SN-1:0] m,
                             input int lim, input int wr_cyc);
        bit gd, ge; int cyc;
        clear_log(); stub_hang = 1'b1;
        issue(op, 19'h00100, 16'h1234, m);
        wait_end(gd, ge, cyc);
        chk(ge && !gd, "R7", "timeout error pulse", {gd, ge}, 2'b01);
        chk(cyc >= lim && cyc <= lim + wr_cyc + 20, "R7", "timeout cycles", cyc, lim);
        chk(!busy_o, "R7", "idle after timeout", busy_o, 0);
        stub_hang = 1'b0; stub_cnt = 0;
        @(negedge clk);
    endtask

    task automatic t_reject(input logic [1:0] op, input logic [SN-1:0] m);
        clear_log();
        issue(op, '0, '0, m);
        chk(err_o && !busy_o, "R8", "reject error pulse", {err_o, busy_o}, 2'b10);
        repeat (30) @(negedge clk);
        chk(nw == 0, "R8", "no bus writes on reject", nw, 0);
    endtask

    task automatic t_busy_ignore();
        bit gd, ge; int cyc;
        clear_log(); stub_delay = 20;
        issue(2'd0, 19'h7ABCD, 16'h0042, '0);
        repeat (10) @(negedge clk);
        issue(2'd2, '0, '0, '0);
        wait_end(gd, ge, cyc);
        chk(nw == 4, "R9", "writes unchanged by busy command", nw, 4);
        chk_write("R9", 3, 19'h7ABCD, 16'h0042);
        chk(gd && !ge, "R9", "result unchanged", {gd, ge}, 2'b10);
        repeat (40) @(negedge clk);
        chk(nw == 4 && !busy_o, "R9", "no late start", nw, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_program(19'h12345, 16'h5A3C, 20);
        t_program(19'h00777, 16'h00C1, 300);
        t_sector_erase();
        t_chip_erase();
        t_timeout(2'd0, '0, PGM_US * MHZ, 48);
        t_timeout(2'd1, 8'h01, SEC_US * MHZ, 72);
        t_reject(2'd1, '0);
        t_reject(2'd3, 8'hFF);
        t_busy_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule